// File: doc/BRIEF.md
# Compressed Table-Jump Execution Unit

This unit carries out the two 16-bit table-jump instructions of a RISC-V core. The pipeline presents one fetched halfword with its PC, the current privilege level, a virtualization flag, the jump-table CSR and bit 2 of each of the three state-enable CSRs. The unit stores all of these in one cycle and then works on the stored copy. It decodes the plain form and the linking form, and it checks that the table is reachable from the current privilege level. If that check passes, it reads one XLEN-wide table entry through a simple request/response port and returns the entry, with bit 0 cleared, as the new PC. For the linking form it also returns a write of PC+2 to x1.

When something goes wrong, the unit reports one exception with its cause code and produces no jump and no register write. The possible causes are an undecodable halfword, a disabled table, the wrong jump-table mode, and a failed table read. Each instruction ends with a single-cycle completion pulse. Address translation, the CSR file and the pipeline are outside this block.

Top module: `tbljmp_unit`

## Requirements
- R1: A halfword whose bits [15:7] are 101000000 and whose bits [1:0] are 10 is a plain table jump. Its index is bits [6:2]. It produces a redirect and no write to x1.
- R2: A halfword whose bits [15:10] are 101000, whose bits [1:0] are 10 and whose bits [9:2] hold an index of 32 to 255 is a linking table jump. An index below 32 in that layout is the plain form of R1. Any halfword matching neither form raises cause 2 (illegal instruction).
- R3: The jump-table CSR holds the table base in bits [XLEN-1:6] and a mode in bits [5:0]. A nonzero mode raises cause 2.
- R4: The single read is issued at address {CSR[XLEN-1:6], 6'b0} + index * (XLEN/8).
- R5: The redirect PC is the XLEN-bit read data with bit 0 forced to zero.
- R6: The linking form writes PC+2, modulo 2^XLEN, to x1. The plain form never asserts the x1 write.
- R7: Privilege is encoded as U=0, S=1, M=3. With machine state-enable present, any level except M raises cause 2 when machine bit 2 is 0. With supervisor state-enable present, non-virtualized U raises cause 2 when supervisor bit 2 is 0. Non-virtualized S ignores the supervisor bit.
- R8: If R7 raises nothing, VS (virtualized S) raises cause 22 (virtual instruction) when hypervisor bit 2 is 0. VU raises cause 22 when the supervisor or the hypervisor bit 2 is 0. The checks of R7 and R8 take precedence over the mode check of R3.
- R9: A table read answered with an access fault raises cause 1 (fetch access fault) instead of a redirect.
- R10: A decode, permission or mode failure issues no memory request. No exception is ever accompanied by a redirect or an x1 write.
- R11: busy rises the cycle after acceptance and stays high through the done cycle. done lasts one cycle. The memory request lasts one cycle, and an issue presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered; taken when idle |
| issue_instr | input | 16 | Fetched halfword |
| issue_pc | input | XLEN | PC of the halfword |
| priv_mode | input | 2 | Privilege level (U=0, S=1, M=3) |
| virt_mode | input | 1 | Virtualized execution |
| jtab_csr | input | XLEN | Jump-table CSR (base and mode) |
| men_bit | input | 1 | Bit 2 of the machine state-enable CSR |
| sen_bit | input | 1 | Bit 2 of the supervisor state-enable CSR |
| hen_bit | input | 1 | Bit 2 of the hypervisor state-enable CSR |
| mem_req_valid | output | 1 | Table read request |
| mem_req_addr | output | XLEN | Table entry address |
| mem_rsp_valid | input | 1 | Read response |
| mem_rsp_data | input | XLEN | Read data |
| mem_rsp_fault | input | 1 | Read failed its access check |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Completion pulse |
| redirect_valid | output | 1 | Jump taken (with done) |
| redirect_pc | output | XLEN | Jump target |
| link_we | output | 1 | Write x1 (with done) |
| link_data | output | XLEN | Value for x1 |
| exc_valid | output | 1 | Exception (with done) |
| exc_cause | output | 5 | Exception cause code |

## Verification
A wrong state in the sequencer shows up as a missing, repeated or stretched request or done pulse. An exception path that falls through to the request state gives a memory request. Either appears within two to three cycles of acceptance. A stale result register shows up in the same done cycle as an exception paired with a redirect or an x1 write, or as a redirect PC with bit 0 set. Misdecoded fields show up as a wrong table address on the request, or as a wrong link flag at done.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_REQ   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_DONE  = 3'd4
  } tj_state_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [4:0] CAUSE_NONE    = 5'd0;
  localparam logic [4:0] CAUSE_FETCHAF = 5'd1;
  localparam logic [4:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [4:0] CAUSE_VIRTUAL = 5'd22;

  typedef struct packed {
    logic       hit;
    logic       link;
    logic [7:0] idx;
  } tj_dec_t;

endpackage

// File: rtl/tbljmp_decode.sv
module tbljmp_decode
  import tbljmp_pkg::*;
(
  input  logic [15:0] instr,
  output tj_dec_t     dec
);
  logic quad_ok;
  logic plain_hit;
  logic link_hit;

  always_comb begin
    quad_ok   = (instr[1:0] == 2'b10);
    plain_hit = quad_ok && (instr[15:7] == 9'b101000000);
    link_hit  = quad_ok && (instr[15:10] == 6'b101000) && (instr[9:7] != 3'b000);
    dec.hit   = plain_hit || link_hit;
    dec.link  = link_hit;
    dec.idx   = plain_hit ? {3'b000, instr[6:2]} : instr[9:2];
  end
endmodule

// File: rtl/tbljmp_perm.sv
module tbljmp_perm
  import tbljmp_pkg::*;
#(
  parameter bit HAS_MSTATE = 1'b1,
  parameter bit HAS_SSTATE = 1'b1
) (
  input  logic       dec_hit,
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       men,
  input  logic       sen,
  input  logic       hen,
  input  logic       tbl_mode_nz,
  output logic       fail,
  output logic [4:0] cause
);
  logic is_m, is_u, is_vs, is_vu;
  logic ill_se, vir_se;

  always_comb begin
    is_m   = (priv == PRIV_M);
    is_u   = !virt && (priv == PRIV_U);
    is_vs  = virt && (priv == PRIV_S);
    is_vu  = virt && (priv == PRIV_U);
    ill_se = (HAS_MSTATE && !is_m && !men) || (HAS_SSTATE && is_u && !sen);
    vir_se = HAS_SSTATE && ((is_vs && !hen) || (is_vu && (!sen || !hen)));

    fail  = 1'b1;
    cause = CAUSE_ILLEGAL;
    if (!dec_hit) begin
      cause = CAUSE_ILLEGAL;
    end else if (ill_se) begin
      cause = CAUSE_ILLEGAL;
    end else if (vir_se) begin
      cause = CAUSE_VIRTUAL;
    end else if (tbl_mode_nz) begin
      cause = CAUSE_ILLEGAL;
    end else begin
      fail  = 1'b0;
      cause = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/tbljmp_addr.sv
module tbljmp_addr #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] csr,
  input  logic [7:0]      idx,
  output logic [XLEN-1:0] addr
);
  localparam int ENTRY_BYTES = XLEN / 8;
  localparam int ENTRY_SH    = $clog2(ENTRY_BYTES);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  always_comb begin
    base = {csr[XLEN-1:6], 6'b000000};
    offs = XLEN'(idx) << ENTRY_SH;
    addr = base + offs;
  end
endmodule

// File: rtl/tbljmp_ctrl.sv
module tbljmp_ctrl
  import tbljmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      issue_valid,
  input  logic      chk_fail,
  input  logic      rsp_valid,
  output tj_state_e state_q,
  output logic      accept,
  output logic      check_load,
  output logic      rsp_take
);
  tj_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (issue_valid) state_d = ST_CHECK;
      ST_CHECK: state_d = chk_fail ? ST_DONE : ST_REQ;
      ST_REQ:   state_d = ST_WAIT;
      ST_WAIT:  if (rsp_valid) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    accept     = (state_q == ST_IDLE) && issue_valid;
    check_load = (state_q == ST_CHECK);
    rsp_take   = (state_q == ST_WAIT) && rsp_valid;
  end
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
  import tbljmp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit HAS_MSTATE = 1'b1,
  parameter bit HAS_SSTATE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [15:0]     issue_instr,
  input  logic [XLEN-1:0] issue_pc,
  input  logic [1:0]      priv_mode,
  input  logic            virt_mode,
  input  logic [XLEN-1:0] jtab_csr,
  input  logic            men_bit,
  input  logic            sen_bit,
  input  logic            hen_bit,
  output logic            mem_req_valid,
  output logic [XLEN-1:0] mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  input  logic            mem_rsp_fault,
  output logic            busy,
  output logic            done,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            link_we,
  output logic [XLEN-1:0] link_data,
  output logic            exc_valid,
  output logic [4:0]      exc_cause
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  tj_state_e state_q;
  logic      accept, check_load, rsp_take;
  logic      chk_fail;
  logic [4:0] chk_cause;

  // captured instruction context
  logic [15:0]     instr_q;
  logic [XLEN-1:0] pc_q, csr_q;
  logic [1:0]      priv_q;
  logic            virt_q, men_q, sen_q, hen_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      instr_q <= '0;
      pc_q    <= '0;
      csr_q   <= '0;
      priv_q  <= PRIV_M;
      virt_q  <= 1'b0;
      men_q   <= 1'b0;
      sen_q   <= 1'b0;
      hen_q   <= 1'b0;
    end else if (accept) begin
      instr_q <= issue_instr;
      pc_q    <= issue_pc;
      csr_q   <= jtab_csr;
      priv_q  <= priv_mode;
      virt_q  <= virt_mode;
      men_q   <= men_bit;
      sen_q   <= sen_bit;
      hen_q   <= hen_bit;
    end
  end

  tj_dec_t dec;
  tbljmp_decode u_dec (
    .instr (instr_q),
    .dec   (dec)
  );

  tbljmp_perm #(
    .HAS_MSTATE (HAS_MSTATE),
    .HAS_SSTATE (HAS_SSTATE)
  ) u_perm (
    .dec_hit     (dec.hit),
    .priv        (priv_q),
    .virt        (virt_q),
    .men         (men_q),
    .sen         (sen_q),
    .hen         (hen_q),
    .tbl_mode_nz (csr_q[5:0] != 6'd0),
    .fail        (chk_fail),
    .cause       (chk_cause)
  );

  logic [XLEN-1:0] entry_addr;
  tbljmp_addr #(.XLEN(XLEN)) u_addr (
    .csr  (csr_q),
    .idx  (dec.idx),
    .addr (entry_addr)
  );

  tbljmp_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .issue_valid (issue_valid),
    .chk_fail    (chk_fail),
    .rsp_valid   (mem_rsp_valid),
    .state_q     (state_q),
    .accept      (accept),
    .check_load  (check_load),
    .rsp_take    (rsp_take)
  );

  // result registers
  logic            exc_q;
  logic [4:0]      cause_q;
  logic [XLEN-1:0] target_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      exc_q    <= 1'b0;
      cause_q  <= CAUSE_NONE;
      target_q <= '0;
    end else if (check_load) begin
      exc_q   <= chk_fail;
      cause_q <= chk_cause;
    end else if (rsp_take) begin
      exc_q    <= mem_rsp_fault;
      cause_q  <= mem_rsp_fault ? CAUSE_FETCHAF : CAUSE_NONE;
      target_q <= mem_rsp_data & ~XLEN'(1);
    end
  end

  always_comb begin
    busy           = (state_q != ST_IDLE);
    done           = (state_q == ST_DONE);
    mem_req_valid  = (state_q == ST_REQ);
    mem_req_addr   = entry_addr;
    redirect_valid = done && !exc_q;
    redirect_pc    = target_q;
    link_we        = done && !exc_q && dec.link;
    link_data      = pc_q + XLEN'(2);
    exc_valid      = done && exc_q;
    exc_cause      = exc_valid ? cause_q : CAUSE_NONE;
  end
endmodule

// File: rtl/tbljmp_unit_chk.sv
module tbljmp_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            mem_req_valid,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            link_we,
  input logic            exc_valid,
  input logic [4:0]      exc_cause
);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  // R11
  busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || done) |-> busy);

  // R11
  req_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !done);

  // R10
  exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!redirect_valid && !link_we));

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (exc_valid != redirect_valid));

  // R6
  link_with_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redirect_valid);

  // R5
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (redirect_pc[0] == 1'b0));

  // R9
  cause_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == 5'd1 || exc_cause == 5'd2 || exc_cause == 5'd22));
endmodule

bind tbljmp_unit tbljmp_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .busy           (busy),
  .done           (done),
  .mem_req_valid  (mem_req_valid),
  .redirect_valid (redirect_valid),
  .redirect_pc    (redirect_pc),
  .link_we        (link_we),
  .exc_valid      (exc_valid),
  .exc_cause      (exc_cause)
);

// File: tb/tbljmp_unit_tb_top.sv
`timescale 1ns/1ps
module tbljmp_unit_tb_top;
  localparam int XLEN = 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            issue_valid;
  logic [15:0]     issue_instr;
  logic [XLEN-1:0] issue_pc;
  logic [1:0]      priv_mode;
  logic            virt_mode;
  logic [XLEN-1:0] jtab_csr;
  logic            men_bit, sen_bit, hen_bit;
  logic            mem_req_valid;
  logic [XLEN-1:0] mem_req_addr;
  logic            mem_rsp_valid;
  logic [XLEN-1:0] mem_rsp_data;
  logic            mem_rsp_fault;
  logic            busy, done, redirect_valid, link_we, exc_valid;
  logic [XLEN-1:0] redirect_pc, link_data;
  logic [4:0]      exc_cause;

  always #4 clk = ~clk;

  tbljmp_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .issue_valid(issue_valid), .issue_instr(issue_instr), .issue_pc(issue_pc),
    .priv_mode(priv_mode), .virt_mode(virt_mode), .jtab_csr(jtab_csr),
    .men_bit(men_bit), .sen_bit(sen_bit), .hen_bit(hen_bit),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault),
    .busy(busy), .done(done), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .link_we(link_we), .link_data(link_data), .exc_valid(exc_valid), .exc_cause(exc_cause)
  );

  int n_chk = 0;
  int n_err = 0;

  // observations of the last operation
  int              o_req;
  logic            o_done, o_busy_bad;
  logic [XLEN-1:0] o_addr, o_pc, o_link;
  logic            o_redir, o_lwe, o_exc;
  logic [4:0]      o_cause;

  localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
  localparam logic [XLEN-1:0] TBL = 32'h8000_1000;

  function automatic logic [15:0] enc_jt(input logic [4:0] i);
    return {9'b101000000, i, 2'b10};
  endfunction

  function automatic logic [15:0] enc_jalt(input logic [7:0] i);
    return {6'b101000, i, 2'b10};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0] ins, input logic [XLEN-1:0] pc, input logic [1:0] pm,
                        input logic v, input logic [XLEN-1:0] csr, input logic m2, input logic s2,
                        input logic h2, input logic [XLEN-1:0] data, input logic flt,
                        input int dly, input bit hold);
    int wn;
    wn = 0;
    o_req = 0; o_done = 1'b0; o_busy_bad = 1'b0; o_addr = '0;
    o_pc = '0; o_link = '0; o_redir = 1'b0; o_lwe = 1'b0; o_exc = 1'b0; o_cause = '0;
    issue_valid = 1'b1; issue_instr = ins; issue_pc = pc; priv_mode = pm; virt_mode = v;
    jtab_csr = csr; men_bit = m2; sen_bit = s2; hen_bit = h2;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_fault = 1'b0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (hold) begin
        issue_instr = enc_jalt(8'd100);
        jtab_csr    = 32'h0000_4000;
      end else begin
        issue_valid = 1'b0;
      end
      if (done) begin
        o_done = 1'b1; o_redir = redirect_valid; o_pc = redirect_pc; o_lwe = link_we;
        o_link = link_data; o_exc = exc_valid; o_cause = exc_cause;
        if (!busy) o_busy_bad = 1'b1;
        issue_valid = 1'b0;
        break;
      end
      if (!busy) o_busy_bad = 1'b1;
      if (mem_req_valid) begin
        o_req++;
        o_addr = mem_req_addr;
        wn = dly + 1;
      end else if (wn > 0) begin
        wn--;
        if (wn == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = data; mem_rsp_fault = flt;
        end
      end
    end
    issue_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic expect_jump(input string req, input logic [XLEN-1:0] addr,
                             input logic [XLEN-1:0] tgt, input logic lwe, input logic [XLEN-1:0] lnk);
    chk(req, "done seen", o_done, 1'b1);
    chk(req, "request count", o_req, 1);
    chk(req, "table address", o_addr, addr);
    chk(req, "redirect valid", o_redir, 1'b1);
    chk(req, "redirect pc", o_pc, tgt);
    chk(req, "exception", o_exc, 1'b0);
    chk(req, "x1 write", o_lwe, lwe);
    if (lwe) chk(req, "x1 value", o_link, lnk);
    chk("R11", "busy held", o_busy_bad, 1'b0);
  endtask

  task automatic expect_exc(input string req, input logic [4:0] cause, input int reqs);
    chk(req, "done seen", o_done, 1'b1);
    chk(req, "exception", o_exc, 1'b1);
    chk(req, "cause", o_cause, cause);
    chk("R10", "no redirect", o_redir, 1'b0);
    chk("R10", "no x1 write", o_lwe, 1'b0);
    chk("R10", "request count", o_req, reqs);
  endtask

  task automatic test_reset;
    chk("R11", "reset busy", busy, 1'b0);
    chk("R11", "reset done", done, 1'b0);
    chk("R11", "reset request", mem_req_valid, 1'b0);
  endtask

  task automatic test_plain;
    run_op(enc_jt(5'd5), 32'h0000_0200, PU, 1'b0, TBL, 1, 1, 1, 32'h1234_5677, 0, 0, 0);
    expect_jump("R1", TBL + 32'd20, 32'h1234_5676, 1'b0, '0);
    run_op(enc_jt(5'd31), 32'h0000_0300, PS, 1'b0, 32'h0000_2040, 1, 1, 1, 32'hFFFF_FFFF, 0, 3, 0);
    expect_jump("R4", 32'h0000_20BC, 32'hFFFF_FFFE, 1'b0, '0);
  endtask

  task automatic test_link;
    run_op(enc_jalt(8'd32), 32'h0000_0100, PU, 1'b0, TBL, 1, 1, 1, 32'h0000_0801, 0, 1, 0);
    expect_jump("R6", TBL + 32'd128, 32'h0000_0800, 1'b1, 32'h0000_0102);
    run_op(enc_jalt(8'd255), 32'hFFFF_FFFE, PM, 1'b0, TBL, 0, 0, 0, 32'h0000_4444, 0, 2, 0);
    expect_jump("R2", TBL + 32'd1020, 32'h0000_4444, 1'b1, 32'h0000_0000);
  endtask

  task automatic test_decode_edges;
    // R2: index below 32 in the linking layout is the plain form
    run_op(enc_jalt(8'd7), 32'h0000_0400, PU, 1'b0, TBL, 1, 1, 1, 32'h0000_9000, 0, 0, 0);
    expect_jump("R2", TBL + 32'd28, 32'h0000_9000, 1'b0, '0);
    run_op(16'h0001, 32'h0, PM, 1'b0, TBL, 1, 1, 1, 32'h0, 0, 0, 0);
    expect_exc("R2", 5'd2, 0);
    run_op(16'hA003, 32'h0, PM, 1'b0, TBL, 1, 1, 1, 32'h0, 0, 0, 0);
    expect_exc("R2", 5'd2, 0);
  endtask

  task automatic test_mode;
    run_op(enc_jt(5'd1), 32'h0, PM, 1'b0, TBL | 32'h3, 1, 1, 1, 32'h0, 0, 0, 0);
    expect_exc("R3", 5'd2, 0);
  endtask

  task automatic test_illegal_gate;
    run_op(enc_jt(5'd2), 32'h0, PS, 1'b0, TBL, 0, 1, 1, 32'h0, 0, 0, 0);
    expect_exc("R7", 5'd2, 0);
    run_op(enc_jt(5'd2), 32'h0, PU, 1'b0, TBL, 1, 0, 1, 32'h0, 0, 0, 0);
    expect_exc("R7", 5'd2, 0);
    run_op(enc_jt(5'd2), 32'h0, PS, 1'b1, TBL, 0, 1, 1, 32'h0, 0, 0, 0);
    expect_exc("R7", 5'd2, 0);
    // R7: M ignores every enable bit; plain S ignores the supervisor bit
    run_op(enc_jt(5'd3), 32'h0, PM, 1'b0, TBL, 0, 0, 0, 32'h0000_0AA0, 0, 0, 0);
    expect_jump("R7", TBL + 32'd12, 32'h0000_0AA0, 1'b0, '0);
    run_op(enc_jt(5'd3), 32'h0, PS, 1'b0, TBL, 1, 0, 0, 32'h0000_0BB0, 0, 0, 0);
    expect_jump("R7", TBL + 32'd12, 32'h0000_0BB0, 1'b0, '0);
  endtask

  task automatic test_virtual_gate;
    run_op(enc_jt(5'd4), 32'h0, PS, 1'b1, TBL, 1, 1, 0, 32'h0, 0, 0, 0);
    expect_exc("R8", 5'd22, 0);
    run_op(enc_jt(5'd4), 32'h0, PU, 1'b1, TBL, 1, 0, 1, 32'h0, 0, 0, 0);
    expect_exc("R8", 5'd22, 0);
    run_op(enc_jt(5'd4), 32'h0, PU, 1'b1, TBL, 1, 1, 0, 32'h0, 0, 0, 0);
    expect_exc("R8", 5'd22, 0);
    run_op(enc_jt(5'd4), 32'h0, PS, 1'b1, TBL | 32'h1, 1, 1, 0, 32'h0, 0, 0, 0);
    expect_exc("R8", 5'd22, 0);
    run_op(enc_jalt(8'd33), 32'h0000_0010, PS, 1'b1, TBL, 1, 0, 1, 32'h0000_0CC1, 0, 0, 0);
    expect_jump("R8", TBL + 32'd132, 32'h0000_0CC0, 1'b1, 32'h0000_0012);
  endtask

  task automatic test_fault;
    run_op(enc_jalt(8'd40), 32'h0000_0020, PM, 1'b0, TBL, 1, 1, 1, 32'h0000_1235, 1, 1, 0);
    expect_exc("R9", 5'd1, 1);
    chk("R9", "faulting address", o_addr, TBL + 32'd160);
  endtask

  task automatic test_busy_ignore;
    run_op(enc_jt(5'd2), 32'h0000_0050, PM, 1'b0, TBL, 1, 1, 1, 32'h0000_7770, 0, 4, 1);
    expect_jump("R11", TBL + 32'd8, 32'h0000_7770, 1'b0, '0);
    chk("R11", "idle after done", busy, 1'b0);
    @(negedge clk);
    chk("R11", "no late request", mem_req_valid, 1'b0);
    chk("R11", "still idle", busy, 1'b0);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    issue_valid = 1'b0; issue_instr = '0; issue_pc = '0; priv_mode = PM; virt_mode = 1'b0;
    jtab_csr = '0; men_bit = 1'b1; sen_bit = 1'b1; hen_bit = 1'b1;
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_rsp_fault = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_plain();
    test_link();
    test_decode_edges();
    test_mode();
    test_illegal_gate();
    test_virtual_gate();
    test_fault();
    test_busy_ignore();
    finish_run();
  end
endmodule